// File: doc/BRIEF.md
# SAR Converter State and Power Sequencer

This block is the device-side controller of a successive-approximation converter. It tracks the converter through four states: power-up, idle, acquisition and conversion. It does so from the conversion-control pin and from a free-running tick that the on-chip oscillator supplies. A falling edge on the control pin moves an idle converter into acquisition. A rising edge ends the acquisition and starts a conversion of fixed length. When the conversion ends, the block returns to idle.

The 2-bit power-mode field is sampled when a conversion completes. That mode then decides three things:
- whether idle keeps everything powered, enters a light sleep, or shuts down all but the oscillator and the interface;
- how many ticks of acquisition (including wake-up) the next sample needs;
- whether a conversion started too early is flagged.

The block also opens a serial-transfer window at the start of each conversion. All time spans are tick counts set by parameters.

Top module: `sar_seq_top`

## Requirements
- R1: The reset state is power-up (state code 0) with every other output low. After PWRUP_TICKS ticks the block enters idle (code 1) in continuous mode, and it never returns to power-up until the next reset.
- R2: From idle, only a falling edge on cnv_i enters acquisition (code 2). In idle, holding cnv_i high or low, or a rising edge, has no effect.
- R3: In acquisition, a rising edge on cnv_i enters conversion (code 3). conv_start_o pulses for exactly the first cycle of the conversion.
- R4: A conversion lasts CONV_TICKS ticks and then returns to idle, with conv_done_o pulsing for the first idle cycle. Edges on cnv_i during a conversion are ignored.
- R5: The power mode is pm_i = 00 for power-down, 01 for continuous and 1x for sleep (bit 1 wins). It is sampled only on the tick that ends a conversion, so changes of pm_i at other times have no effect.
- R6: sleep_o is high only in idle under sleep mode. pdn_o is high only in idle under power-down mode. Neither is high in continuous mode or outside idle.
- R7: In acquisition, acq_ok_o goes high once the ticks since entry reach the minimum for the sampled mode: ACQ_RUN_TICKS, ACQ_SLEEP_TICKS or ACQ_PDN_TICKS.
- R8: A rising edge on cnv_i in acquisition before acq_ok_o is high still starts the conversion, and it sets acq_viol_o. acq_viol_o stays high until reset.
- R9: xfer_o is high during the first XFER_TICKS ticks of each conversion and low at all other times.
- R10: All time counting advances only on cycles with tick_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oscillator tick, one-cycle enable |
| cnv_i | input | 1 | Conversion control (synchronous) |
| pm_i | input | 2 | Power-mode field |
| state_o | output | 2 | 0 power-up, 1 idle, 2 acquisition, 3 conversion |
| acq_ok_o | output | 1 | Minimum acquisition reached |
| conv_start_o | output | 1 | Conversion start pulse |
| conv_done_o | output | 1 | Conversion done pulse |
| xfer_o | output | 1 | Serial transfer window open |
| acq_viol_o | output | 1 | Sticky early-conversion flag |
| sleep_o | output | 1 | Sleep domain active |
| pdn_o | output | 1 | Power-down domain active |

## Verification
The bench builds the block with small counts:
- PWRUP_TICKS = 3
- CONV_TICKS = 6
- XFER_TICKS = 2
- ACQ_RUN_TICKS = 2, ACQ_SLEEP_TICKS = 4, ACQ_PDN_TICKS = 8

With these values, every acquisition threshold can be hit exactly, one tick early and one tick late in a few cycles. The end of the transfer window and the last tick of a conversion become cycle-exact checks. Gating tick_i shows that the counters freeze and that violations persist across several conversions under all three modes.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [1:0] {
    ST_PWRUP = 2'd0,
    ST_IDLE  = 2'd1,
    ST_ACQ   = 2'd2,
    ST_CONV  = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    PM_PDN   = 2'd0,
    PM_RUN   = 2'd1,
    PM_SLEEP = 2'd2
  } pwr_mode_e;

  // bit 1 overrides bit 0
  function automatic pwr_mode_e decode_pm(input logic [1:0] pm);
    if (pm[1])      return PM_SLEEP;
    else if (pm[0]) return PM_RUN;
    else            return PM_PDN;
  endfunction
endpackage

// File: rtl/sar_tick_ctr.sv
module sar_tick_ctr #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] SAT = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i)                 cnt_q <= '0;
    else if (tick_i && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  AST_CTR_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i) |=> $stable(cnt_q)); // R10
  AST_CTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && tick_i && cnt_q != SAT) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R10
endmodule

// File: rtl/sar_pwr_ctl.sv
module sar_pwr_ctl
  import sar_seq_pkg::*;
#(
  parameter int W               = 12,
  parameter int ACQ_RUN_TICKS   = 8,
  parameter int ACQ_SLEEP_TICKS = 21,
  parameter int ACQ_PDN_TICKS   = 1508
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [1:0]   pm_i,
  input  logic         idle_i,
  output logic [W-1:0] need_o,
  output logic         sleep_o,
  output logic         pdn_o
);
  localparam logic [W-1:0] NEED_RUN   = W'(ACQ_RUN_TICKS);
  localparam logic [W-1:0] NEED_SLEEP = W'(ACQ_SLEEP_TICKS);
  localparam logic [W-1:0] NEED_PDN   = W'(ACQ_PDN_TICKS);

  pwr_mode_e mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= PM_RUN;
    else if (load_i) mode_q <= decode_pm(pm_i);
  end

  always_comb begin
    unique case (mode_q)
      PM_SLEEP: need_o = NEED_SLEEP;
      PM_PDN:   need_o = NEED_PDN;
      default:  need_o = NEED_RUN;
    endcase
  end

  assign sleep_o = idle_i && (mode_q == PM_SLEEP);
  assign pdn_o   = idle_i && (mode_q == PM_PDN);

  AST_LOWPWR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sleep_o && pdn_o)); // R6
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mode_q)); // R5
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top
  import sar_seq_pkg::*;
#(
  parameter int PWRUP_TICKS     = 16,
  parameter int CONV_TICKS      = 72,
  parameter int XFER_TICKS      = 32,
  parameter int ACQ_RUN_TICKS   = 8,
  parameter int ACQ_SLEEP_TICKS = 21,
  parameter int ACQ_PDN_TICKS   = 1508
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       cnv_i,
  input  logic [1:0] pm_i,
  output logic [1:0] state_o,
  output logic       acq_ok_o,
  output logic       conv_start_o,
  output logic       conv_done_o,
  output logic       xfer_o,
  output logic       acq_viol_o,
  output logic       sleep_o,
  output logic       pdn_o
);
  localparam int M1    = (PWRUP_TICKS > CONV_TICKS) ? PWRUP_TICKS : CONV_TICKS;
  localparam int M2    = (ACQ_PDN_TICKS > ACQ_SLEEP_TICKS) ? ACQ_PDN_TICKS : ACQ_SLEEP_TICKS;
  localparam int M3    = (M2 > ACQ_RUN_TICKS) ? M2 : ACQ_RUN_TICKS;
  localparam int MAXT  = (M1 > M3) ? M1 : M3;
  localparam int CW    = $clog2(MAXT + 2);
  localparam logic [CW-1:0] LIM_PWRUP = CW'(PWRUP_TICKS);
  localparam logic [CW-1:0] LIM_CONV  = CW'(CONV_TICKS);
  localparam logic [CW-1:0] LIM_XFER  = CW'(XFER_TICKS);

  seq_state_e  state_q, state_d;
  logic        cnv_q, cnv_rise, cnv_fall;
  logic [CW-1:0] phase_cnt, phase_lim, acq_cnt, acq_need;
  logic        phase_hit, phase_clr, acq_clr, acq_reached;
  logic        start_q, done_q, viol_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnv_q <= 1'b0;
    else         cnv_q <= cnv_i;
  end
  assign cnv_rise = cnv_i && !cnv_q;
  assign cnv_fall = !cnv_i && cnv_q;

  assign phase_lim = (state_q == ST_PWRUP) ? LIM_PWRUP : LIM_CONV;
  assign phase_hit = tick_i && (phase_cnt == phase_lim - 1'b1);
  assign phase_clr = (state_d != state_q);
  assign acq_clr   = (state_q != ST_ACQ);

  sar_tick_ctr #(.W(CW)) u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (phase_clr),
    .tick_i (tick_i),
    .cnt_o  (phase_cnt)
  );

  sar_tick_ctr #(.W(CW)) u_acq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (acq_clr),
    .tick_i (tick_i),
    .cnt_o  (acq_cnt)
  );

  sar_pwr_ctl #(
    .W               (CW),
    .ACQ_RUN_TICKS   (ACQ_RUN_TICKS),
    .ACQ_SLEEP_TICKS (ACQ_SLEEP_TICKS),
    .ACQ_PDN_TICKS   (ACQ_PDN_TICKS)
  ) u_pwr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (state_q == ST_CONV && phase_hit),
    .pm_i    (pm_i),
    .idle_i  (state_q == ST_IDLE),
    .need_o  (acq_need),
    .sleep_o (sleep_o),
    .pdn_o   (pdn_o)
  );

  assign acq_reached = (acq_cnt >= acq_need);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PWRUP: if (phase_hit) state_d = ST_IDLE;
      ST_IDLE:  if (cnv_fall)  state_d = ST_ACQ;
      ST_ACQ:   if (cnv_rise)  state_d = ST_CONV;
      ST_CONV:  if (phase_hit) state_d = ST_IDLE;
      default:                 state_d = ST_PWRUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWRUP;
      start_q <= 1'b0;
      done_q  <= 1'b0;
      viol_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= (state_q == ST_ACQ) && cnv_rise;
      done_q  <= (state_q == ST_CONV) && phase_hit;
      if ((state_q == ST_ACQ) && cnv_rise && !acq_reached) viol_q <= 1'b1;
    end
  end

  assign state_o      = state_q;
  assign acq_ok_o     = (state_q == ST_ACQ) && acq_reached;
  assign conv_start_o = start_q;
  assign conv_done_o  = done_q;
  assign xfer_o       = (state_q == ST_CONV) && (phase_cnt < LIM_XFER);
  assign acq_viol_o   = viol_q;

  AST_NO_PWRUP_RETURN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_PWRUP) |=> (state_q != ST_PWRUP)); // R1
  AST_ACQ_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ACQ && $past(state_q) != ST_ACQ) |-> ($past(state_q) == ST_IDLE)); // R2
  AST_START_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> (state_q == ST_CONV && $past(state_q) == ST_ACQ)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_done_o |-> (state_q == ST_IDLE && $past(state_q) == ST_CONV)); // R4
  AST_LOWPWR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_o || pdn_o) |-> (state_q == ST_IDLE)); // R6
  AST_ACQ_OK_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acq_ok_o |-> (state_q == ST_ACQ)); // R7
  AST_VIOL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(acq_viol_o) |-> acq_viol_o); // R8
  AST_XFER_IN_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |-> (state_q == ST_CONV)); // R9
endmodule

// File: tb/sim_sar_seq_top.sv
module sim_sar_seq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       cnv = 1'b1;
  logic [1:0] pm = 2'b01;
  logic [1:0] state;
  logic       acq_ok, conv_start, conv_done, xfer, viol, slp, pdn;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sar_seq_top #(
    .PWRUP_TICKS(3), .CONV_TICKS(6), .XFER_TICKS(2),
    .ACQ_RUN_TICKS(2), .ACQ_SLEEP_TICKS(4), .ACQ_PDN_TICKS(8)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cnv_i(cnv), .pm_i(pm),
    .state_o(state), .acq_ok_o(acq_ok), .conv_start_o(conv_start),
    .conv_done_o(conv_done), .xfer_o(xfer), .acq_viol_o(viol),
    .sleep_o(slp), .pdn_o(pdn)
  );

  // expected: {state, sleep, pdn, acq_ok, viol, xfer, start, done}
  typedef struct packed {
    logic       cnv;
    logic [1:0] pm;
    logic       tick;
    logic [7:0] n;
    logic [8:0] exp;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 2'b01, 1'b1, 8'd2, 9'b00_0000000}, // R1 still powering up
    '{1'b1, 2'b01, 1'b1, 8'd1, 9'b01_0000000}, // R1 idle, continuous
    '{1'b1, 2'b01, 1'b1, 8'd2, 9'b01_0000000}, // R2 high level ignored
    '{1'b0, 2'b01, 1'b1, 8'd1, 9'b10_0000000}, // R2 fall enters acq
    '{1'b0, 2'b01, 1'b1, 8'd1, 9'b10_0000000}, // R7 one tick short
    '{1'b0, 2'b01, 1'b1, 8'd1, 9'b10_0010000}, // R7 run threshold
    '{1'b1, 2'b01, 1'b1, 8'd1, 9'b11_0000110}, // R3 start pulse
    '{1'b1, 2'b10, 1'b1, 8'd1, 9'b11_0000100}, // R9 window tick 1
    '{1'b1, 2'b10, 1'b1, 8'd1, 9'b11_0000000}, // R9 window closed
    '{1'b1, 2'b10, 1'b1, 8'd3, 9'b11_0000000}, // R4 last conv tick
    '{1'b1, 2'b10, 1'b1, 8'd1, 9'b01_1000001}, // R4 R5 done, sleep
    '{1'b1, 2'b10, 1'b1, 8'd1, 9'b01_1000000}, // R6 sleep in idle
    '{1'b0, 2'b10, 1'b1, 8'd1, 9'b10_0000000}, // R6 sleep off in acq
    '{1'b0, 2'b10, 1'b1, 8'd2, 9'b10_0000000}, // R7 sleep needs 4
    '{1'b1, 2'b10, 1'b1, 8'd1, 9'b11_0001110}, // R8 early start
    '{1'b1, 2'b00, 1'b1, 8'd5, 9'b11_0001000}, // R4 conv running
    '{1'b1, 2'b00, 1'b1, 8'd1, 9'b01_0101001}, // R5 power-down mode
    '{1'b1, 2'b01, 1'b1, 8'd4, 9'b01_0101000}, // R5 pm change ignored
    '{1'b0, 2'b01, 1'b1, 8'd8, 9'b10_0001000}, // R7 pdn one short
    '{1'b0, 2'b01, 1'b1, 8'd1, 9'b10_0011000}, // R7 pdn threshold
    '{1'b1, 2'b01, 1'b1, 8'd1, 9'b11_0001110}, // R3 start
    '{1'b0, 2'b01, 1'b1, 8'd1, 9'b11_0001100}, // R4 fall ignored
    '{1'b0, 2'b01, 1'b1, 8'd4, 9'b11_0001000}, // R4 running
    '{1'b0, 2'b01, 1'b1, 8'd1, 9'b01_0001001}, // R5 continuous again
    '{1'b0, 2'b01, 1'b1, 8'd2, 9'b01_0001000}, // R2 low level ignored
    '{1'b1, 2'b01, 1'b1, 8'd1, 9'b01_0001000}, // R2 rise ignored
    '{1'b0, 2'b01, 1'b1, 8'd1, 9'b10_0001000}, // R2 fall enters acq
    '{1'b0, 2'b01, 1'b0, 8'd5, 9'b10_0001000}, // R10 acq frozen
    '{1'b0, 2'b01, 1'b1, 8'd2, 9'b10_0011000}, // R10 resumes
    '{1'b1, 2'b01, 1'b0, 8'd3, 9'b11_0001100}, // R10 conv frozen
    '{1'b1, 2'b01, 1'b1, 8'd6, 9'b01_0001001}  // R4 six ticks
  };

  function automatic logic [8:0] actual();
    return {state, slp, pdn, acq_ok, viol, xfer, conv_start, conv_done};
  endfunction

  task automatic check(input string req, input logic [8:0] exp);
    n_chk++;
    if (actual() !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, actual(), exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", 9'b00_0000000);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      cnv  = TBL[i].cnv;
      pm   = TBL[i].pm;
      tick = TBL[i].tick;
      repeat (int'(TBL[i].n)) @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0s vec %0d", "x", i), TBL[i].exp);
    end
    // R8 R1: reset clears sticky flag and returns to power-up
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 R1 mid-run reset", 9'b00_0000000);
    rst_n = 1'b1;
    tick = 1'b0;
    cnv = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check("R10 R1 power-up frozen", 9'b00_0000000);
    tick = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 idle after power-up", 9'b01_0000000);
    // R8 early start under continuous mode
    cnv = 1'b0;
    @(posedge clk);
    @(negedge clk);
    cnv = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R8 immediate rise", 9'b11_0001110);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule